// File: doc/BRIEF.md
# Interleaved Clock-Enabled Synchronizer

This block carries a single asynchronous bit into a fast clock domain. A plain flop chain gives each stage only one clock period to settle. This block gives each stage several periods. It builds `NUM_PHASES` independent lanes, and a free-running phase counter enables exactly one lane per cycle. Every flop inside a lane therefore updates once every `NUM_PHASES` cycles, so its successor samples it a full `NUM_PHASES` periods after it was loaded.

Because the lanes are staggered one cycle apart, one lane is always due, and the block still produces a fresh result on every clock. A parameter chooses where the lane selection happens:
- **Select before the register:** a single output flop loads from the due lane's last stage.
- **Select after the register:** each lane owns an output flop, and a mux steered by a registered copy of the phase picks among them.

Both variants have the same cycle behaviour. The output equals the input sampled exactly `NUM_PHASES*DEPTH` edges earlier.

Top module: `isync_interleave`

## Requirements
- R1: While `rst` is high at a rising edge, every lane stage, the phase counter and `sync_out` return to 0. `sync_out` reads 0 in the cycle after any reset edge.
- R2: The phase counter starts at 0 after reset and advances by one per clock, wrapping from `NUM_PHASES-1` to 0. Exactly one lane enable is high in every cycle: lane p is enabled when the counter equals p.
- R3: A lane's stages keep their values in every cycle in which that lane is not enabled. When the lane is enabled, stage k (k > 0) loads the previous value of stage k-1.
- R4: After the e-th rising edge following reset release, `sync_out` equals the value `async_in` had at edge e - `NUM_PHASES*DEPTH`, for any input pattern, including single-cycle pulses and toggling on every clock.
- R5: If `async_in` changes before an edge and then holds, `sync_out` takes the new level right after the (`NUM_PHASES*DEPTH`+1)-th edge counted from that edge. It makes no other transition while the input holds.
- R6: For the first `NUM_PHASES*DEPTH` edges after reset release, `sync_out` stays 0 whatever `async_in` does.
- R7: The select-before-register mode (`MODE` = 0) and the select-after-register mode (`MODE` = 1) produce identical `sync_out` sequences for the same input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast destination clock |
| rst | input | 1 | Synchronous active-high reset |
| async_in | input | 1 | Asynchronous single-bit input |
| sync_out | output | 1 | Synchronized copy of the input |

## Verification
The checker watches the internal mechanics on every cycle:
- the phase counter stepping and wrapping;
- one-hot lane enables;
- lanes holding while idle, and capturing and shifting only when enabled;
- the output being low after reset.

The end-to-end relations need the bench's scenarios: the exact delay of `NUM_PHASES*DEPTH` edges, the worst-case latency and freedom from glitches for a held step, the quiet window after reset, and the agreement between the two output variants. The bench shows these with long holds, clock-rate toggling, single-cycle pulses and holds exactly one phase cycle long.

// File: rtl/isync_pkg.sv
package isync_pkg;

   // Where the due lane is selected relative to the output register.
   typedef enum logic {
      SEL_BEFORE_REG = 1'b0,
      SEL_AFTER_REG  = 1'b1
   } sel_mode_e;

   // True when v is a power of two, two or larger.
   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/isync_phase.sv
// Rotating phase counter with a one-hot lane enable decode.
module isync_phase #(
   parameter int N  = 4,
   localparam int CW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst,
   output logic [CW-1:0] cnt,
   output logic [N-1:0]  en
);

   localparam logic [CW-1:0] LAST = CW'(N - 1);
   localparam logic [CW-1:0] STEP = CW'(1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (cnt_q == LAST)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + STEP;
   end

   assign cnt = cnt_q;

   for (genvar p = 0; p < N; p++) begin : g_dec
      localparam logic [CW-1:0] MY_PHASE = CW'(p);
      assign en[p] = (cnt_q == MY_PHASE);
   end

endmodule

// File: rtl/isync_lane.sv
// One interleaved lane: a chain of DEPTH flops that all advance only on
// the lane's enable, plus an optional lane-owned output flop.
module isync_lane #(
   parameter int DEPTH   = 2,
   parameter bit OWN_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             din,
   output logic [DEPTH-1:0] stg,
   output logic             lane_q
);

   for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      logic nxt;
      if (k == 0) begin : g_first
         assign nxt = din;
      end else begin : g_next
         assign nxt = stg[k-1];
      end

      always_ff @(posedge clk) begin
         if (rst)
            stg[k] <= 1'b0;
         else if (en)
            stg[k] <= nxt;
      end
   end

   if (OWN_OUT) begin : g_own
      logic oq;
      always_ff @(posedge clk) begin
         if (rst)
            oq <= 1'b0;
         else if (en)
            oq <= stg[DEPTH-1];
      end
      assign lane_q = oq;
   end else begin : g_shared
      assign lane_q = stg[DEPTH-1];
   end

endmodule

// File: rtl/isync_merge.sv
// Picks the due lane; the variant decides whether the pick precedes or
// follows the output register.
module isync_merge
   import isync_pkg::*;
#(
   parameter int        N    = 4,
   parameter sel_mode_e MODE = SEL_BEFORE_REG,
   localparam int       CW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] cnt,
   input  logic [N-1:0]  lane_q,
   output logic          dout
);

   if (MODE == SEL_BEFORE_REG) begin : g_before
      // The lane enabled now hands its last stage to the single output flop.
      logic oq;
      always_ff @(posedge clk) begin
         if (rst)
            oq <= 1'b0;
         else
            oq <= lane_q[cnt];
      end
      assign dout = oq;
   end else begin : g_after
      // Remember which lane loaded its own flop at the last edge.
      logic [CW-1:0] sel_q;
      always_ff @(posedge clk) begin
         if (rst)
            sel_q <= '0;
         else
            sel_q <= cnt;
      end
      assign dout = lane_q[sel_q];
   end

endmodule

// File: rtl/isync_interleave.sv
// Interleaved clock-enabled synchronizer top.
module isync_interleave
   import isync_pkg::*;
#(
   parameter int        NUM_PHASES = 4,
   parameter int        DEPTH      = 2,
   parameter sel_mode_e MODE       = SEL_BEFORE_REG
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic sync_out
);

   localparam int CW    = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1;
   localparam int TOTAL = NUM_PHASES * DEPTH;
   localparam bit OWN   = (MODE == SEL_AFTER_REG);

   if (!is_pow2(NUM_PHASES)) begin : g_bad_phases
      $error("NUM_PHASES must be a power of two, at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   logic [CW-1:0]         phase_cnt;
   logic [NUM_PHASES-1:0] lane_en;
   logic [NUM_PHASES-1:0] lane_q;
   logic [TOTAL-1:0]      stg_flat;

   isync_phase #(.N(NUM_PHASES)) u_phase (
      .clk (clk),
      .rst (rst),
      .cnt (phase_cnt),
      .en  (lane_en)
   );

   for (genvar p = 0; p < NUM_PHASES; p++) begin : g_lane
      isync_lane #(.DEPTH(DEPTH), .OWN_OUT(OWN)) u_lane (
         .clk    (clk),
         .rst    (rst),
         .en     (lane_en[p]),
         .din    (async_in),
         .stg    (stg_flat[p*DEPTH +: DEPTH]),
         .lane_q (lane_q[p])
      );
   end

   isync_merge #(.N(NUM_PHASES), .MODE(MODE)) u_merge (
      .clk    (clk),
      .rst    (rst),
      .cnt    (phase_cnt),
      .lane_q (lane_q),
      .dout   (sync_out)
   );

endmodule

// File: rtl/isync_interleave_chk.sv
// Cycle-level checks on the synchronizer, attached by bind.
module isync_interleave_chk #(
   parameter int N  = 4,
   parameter int S  = 2,
   localparam int CW = (N > 1) ? $clog2(N) : 1
) (
   input logic          clk,
   input logic          rst,
   input logic          din,
   input logic          dout,
   input logic [CW-1:0] cnt,
   input logic [N-1:0]  en,
   input logic [N*S-1:0] stg
);

   localparam logic [CW-1:0] LAST = CW'(N - 1);
   localparam logic [CW-1:0] STEP = CW'(1);

   logic prev_rst;
   always_ff @(posedge clk) prev_rst <= rst;

   always @(posedge clk) begin
      if (prev_rst === 1'b1)
         AST_RESET_LOW: assert (dout == 1'b0); // R1
   end

   AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
      $countones(en) == 1); // R2
   AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
      (cnt == LAST) |=> (cnt == '0)); // R2
   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
      (cnt != LAST) |=> (cnt == $past(cnt) + STEP)); // R2

   for (genvar p = 0; p < N; p++) begin : g_p
      AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
         !en[p] |=> $stable(stg[p*S +: S])); // R3
      AST_LANE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
         en[p] |=> (stg[p*S] == $past(din))); // R4
      for (genvar k = 1; k < S; k++) begin : g_k
         AST_LANE_SHIFT: assert property (@(posedge clk) disable iff (rst)
            en[p] |=> (stg[p*S+k] == $past(stg[p*S+k-1]))); // R3
      end
   end

endmodule

bind isync_interleave isync_interleave_chk #(.N(NUM_PHASES), .S(DEPTH)) u_chk (
   .clk  (clk),
   .rst  (rst),
   .din  (async_in),
   .dout (sync_out),
   .cnt  (phase_cnt),
   .en   (lane_en),
   .stg  (stg_flat)
);

// File: tb/tb_isync_interleave.sv
module tb_isync_interleave;
   import isync_pkg::*;

   localparam int N   = 4;
   localparam int S   = 2;
   localparam int LAT = N * S;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic din = 1'b0;
   logic dout_a, dout_b;

   int compared   = 0;
   int mismatched = 0;
   bit done       = 1'b0;
   bit sb_on      = 1'b0;
   bit q[$];

   always #10 clk = ~clk; // 50 MHz

   isync_interleave #(.NUM_PHASES(N), .DEPTH(S), .MODE(SEL_BEFORE_REG)) dut (
      .clk(clk), .rst(rst), .async_in(din), .sync_out(dout_a));

   isync_interleave #(.NUM_PHASES(N), .DEPTH(S), .MODE(SEL_AFTER_REG)) dut_alt (
      .clk(clk), .rst(rst), .async_in(din), .sync_out(dout_b));

   task automatic check(input string req, input logic act, input logic exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // Driver side of the scoreboard: each edge out of reset queues the sampled input.
   always @(posedge clk) begin
      if (!rst) q.push_back(din);
      else q.delete();
   end

   // Monitor: expected output is the input from LAT edges earlier, else 0 (R4, R6).
   always @(negedge clk) begin
      if (sb_on && !rst) begin
         logic e;
         e = 1'b0;
         if (q.size() > LAT) e = q.pop_front();
         check("R4", dout_a, e);
         check("R7", dout_b, e);
      end
   end

   task automatic drive(input logic v, input int cycles);
      din = v;
      repeat (cycles) @(negedge clk);
   endtask

   initial begin
      // R1: reset holds outputs low while the input toggles.
      repeat (2) @(negedge clk);
      for (int i = 0; i < 6; i++) begin
         din = ~din;
         @(negedge clk);
         check("R1", dout_a, 1'b0);
         check("R1", dout_b, 1'b0);
      end

      // R6: input high from release, output quiet for LAT edges.
      din = 1'b1;
      rst = 1'b0;
      sb_on = 1'b1;
      for (int i = 0; i < LAT; i++) begin
         @(negedge clk);
         check("R6", dout_a, 1'b0);
         check("R6", dout_b, 1'b0);
      end
      repeat (3 * N) @(negedge clk);

      // R5: a held step appears after exactly LAT+1 edges and never flickers.
      din = 1'b0;
      for (int i = 1; i <= LAT + 3 * N; i++) begin
         @(negedge clk);
         check("R5", dout_a, (i >= LAT + 1) ? 1'b0 : 1'b1);
         check("R5", dout_b, (i >= LAT + 1) ? 1'b0 : 1'b1);
      end

      // R4: toggling every clock, single-cycle pulses, holds of exactly N.
      for (int i = 0; i < 20; i++) drive(~din, 1);
      for (int i = 0; i < 6; i++) begin
         drive(1'b1, 1);
         drive(1'b0, 3 + i);
      end
      for (int i = 0; i < 8; i++) drive(~din, N);
      for (int i = 0; i < 200; i++) drive(1'($urandom_range(0, 1)), 1 + $urandom_range(0, 2 * N));

      // R1: mid-run reset clears output on the next cycle.
      din = 1'b1;
      repeat (LAT + 2) @(negedge clk);
      sb_on = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      check("R1", dout_a, 1'b0);
      check("R1", dout_b, 1'b0);

      // Restart with another pattern after reset release.
      rst = 1'b0;
      sb_on = 1'b1;
      for (int i = 0; i < 40; i++) drive(1'(i % 3 == 0), 1);
      drive(1'b0, LAT + 4);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule